// File: doc/BRIEF.md
# Late-Operand Carry-Select Adder

This is a combinational unsigned adder for a datapath where one operand is wide but settles early and the other is narrow but settles late. The wide operand is zero-extended to the result width W. The sum is then cut once, at bit K, where K is the width of the narrow operand.

Below the cut, a K-bit adder combines the narrow operand with the low bits of the wide operand. It yields the low result bits and one carry. Above the cut, the upper bits of the wide operand are prepared in two forms while the late operand is still on its way: unchanged, and plus one. The low carry then chooses between the two forms through one multiplexer.

The late operand therefore crosses only a K-bit add and a single mux level. The long carry chain hangs entirely on the early operand. Parameter checks at elaboration refuse a split outside 1 <= K < W, a wide operand narrower than K, K above 16, and an upper part narrower than 8 bits.

Top module: `late_narrow_csel_add`

## Requirements
- R1: `sum_out` equals the unsigned sum `wide_in + narrow_in` truncated to W bits, for every input pair.
- R2: The low K bits of `sum_out` equal `(wide_in[K-1:0] + narrow_in)` modulo 2^K.
- R3: The upper W-K bits of `sum_out` equal the zero-extended `wide_in` bits [W-1:K] plus one when `wide_in[K-1:0] + narrow_in` is at least 2^K. Otherwise they equal those bits unchanged.
- R4: When the upper bits of the zero-extended wide operand are all ones and the low part carries, the upper bits of `sum_out` wrap to zero and the carry out of bit W-1 is lost.
- R5: The wide operand is zero-extended. When WA < W, the bits of `sum_out` from WA upward are zero, except that bit WA alone is 1 when the sum overflows WA bits.
- R6: Zero on both operands gives zero on `sum_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wide_in | input | WA | Wide operand that settles early, unsigned |
| narrow_in | input | K | Narrow operand that settles late, unsigned |
| sum_out | output | W | Sum truncated to W bits |

## Verification
The hardest case to reach is the wrap in R4. It requires every upper bit of the zero-extended wide operand to be one, so it cannot happen while WA < W, because the extension bits are always zero. The bench therefore adds a second instance with WA equal to W and drives it with all ones plus a carrying narrow value. On the default instance, directed vectors force a carry across the split, one of them rippling up through all of `wide_in`, while random pairs are compared against a plain wide sum.

// File: rtl/late_narrow_csel_add.sv
module late_narrow_csel_add #(
  parameter int WA = 24,
  parameter int K  = 8,
  parameter int W  = 32
) (
  input  logic [WA-1:0] wide_in,
  input  logic [K-1:0]  narrow_in,
  output logic [W-1:0]  sum_out
);
  localparam int HW = W - K;

  if (K < 1 || K >= W) begin : g_bad_split
    $error("split point out of range");
  end
  if (WA < K || WA > W) begin : g_bad_wide
    $error("wide operand width out of range");
  end
  if (K > 16) begin : g_bad_narrow
    $error("narrow operand too wide");
  end
  if (HW < 8) begin : g_bad_high
    $error("upper part too narrow");
  end

  logic [W-1:0]  wide_ext;
  logic [K:0]    lo_part;
  logic [HW-1:0] hi_keep;
  logic [HW-1:0] hi_bump;
  logic [HW-1:0] hi_pick;
  logic [W-1:0]  ref_sum;

  always_comb begin
    wide_ext = W'(wide_in);
    lo_part  = {1'b0, wide_ext[K-1:0]} + {1'b0, narrow_in};
    hi_keep  = wide_ext[W-1:K];
    hi_bump  = hi_keep + HW'(1);
    hi_pick  = lo_part[K] ? hi_bump : hi_keep;
    sum_out  = {hi_pick, lo_part[K-1:0]};

    ref_sum = wide_ext + W'(narrow_in);
    a_r1_matches_plain_sum: assert (sum_out == ref_sum);
    a_r3_carry_when_low_overflows: assert (lo_part[K] == (narrow_in > ~wide_ext[K-1:0]));
    a_r4_bump_zero_only_on_wrap: assert (hi_bump != '0 || hi_keep == '1);
    a_r5_zero_extension: assert ((sum_out >> WA) <= W'(1));
    a_r6_zero_in_zero_out: assert (wide_in != '0 || narrow_in != '0 || sum_out == '0);
  end
endmodule

// File: tb/test_late_narrow_csel_add.sv
module test_late_narrow_csel_add;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [23:0] wa;
  logic [7:0]  nb;
  logic [31:0] sum;
  logic [15:0] fa;
  logic [7:0]  fb;
  logic [15:0] fsum;

  late_narrow_csel_add #(.WA(24), .K(8), .W(32)) i_late_narrow_csel_add (
    .wide_in(wa), .narrow_in(nb), .sum_out(sum));

  late_narrow_csel_add #(.WA(16), .K(8), .W(16)) i_late_narrow_csel_add_full (
    .wide_in(fa), .narrow_in(fb), .sum_out(fsum));

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  localparam logic [23:0] TA [8] = '{24'h000000, 24'h0000FF, 24'hFFFFFF, 24'h123456,
                                     24'hABCDEF, 24'hFFFF00, 24'h7FFFFF, 24'h000001};
  localparam logic [7:0]  TB [8] = '{8'h00, 8'h01, 8'h01, 8'h78, 8'h11, 8'hFF, 8'h80, 8'hFE};
  localparam logic [31:0] TS [8] = '{32'h00000000, 32'h00000100, 32'h01000000, 32'h001234CE,
                                     32'h00ABCE00, 32'h00FFFFFF, 32'h0080007F, 32'h000000FF};

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [23:0] a, input logic [7:0] b);
    @(negedge clk);
    wa = a;
    nb = b;
    @(posedge clk);
    #2;
  endtask

  task automatic drive_full(input logic [15:0] a, input logic [7:0] b);
    @(negedge clk);
    fa = a;
    fb = b;
    @(posedge clk);
    #2;
  endtask

  initial begin
    wa = '0; nb = '0; fa = '0; fb = '0;
    @(posedge clk);
    #2;
    check("R6 zero operands", sum, 32'h0);

    for (int i = 0; i < 8; i++) begin
      drive(TA[i], TB[i]);
      check("R1 table vector", sum, TS[i]);
    end

    drive(24'h1234F0, 8'h20);
    check("R2 low bits wrap", {24'h0, sum[7:0]}, 32'h10);
    check("R3 upper bits bumped on carry", {8'h0, sum[31:8]}, 32'h1235);
    drive(24'h1234F0, 8'h0F);
    check("R3 upper bits kept without carry", {8'h0, sum[31:8]}, 32'h1234);
    drive(24'hFFFFFF, 8'hFF);
    check("R5 only bit WA set above WA", {24'h0, sum[31:24]}, 32'h1);
    drive(24'hFFFF00, 8'h7F);
    check("R5 no overflow keeps top zero", {24'h0, sum[31:24]}, 32'h0);

    drive_full(16'hFFFF, 8'h01);
    check("R4 wrap to zero", {16'h0, fsum}, 32'h0);
    drive_full(16'hFFFF, 8'hFF);
    check("R4 wrap with low remainder", {16'h0, fsum}, 32'h00FE);
    drive_full(16'hFF80, 8'h7F);
    check("R4 no carry no wrap", {16'h0, fsum}, 32'hFFFF);

    for (int i = 0; i < 300; i++) begin
      logic [23:0] ra;
      logic [7:0]  rb;
      ra = 24'($urandom);
      rb = 8'($urandom);
      drive(ra, rb);
      check("R1 random", sum, 32'(ra) + 32'(rb));
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        #100000;
        total++;
        bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule